// File: doc/BRIEF.md
# Debug Halt and Stop-Reason Controller

This block decides when a processor core must be frozen for a debugger. A host-side control register carries a hold-in-reset bit and a stall bit; the block turns them into a level core-hold output, a one-cycle core restart pulse when the hold bit is dropped, and a core stall output. A mode register selects single-step stopping, gates all stop generation, and carries an override that forces the stall low whatever else requests it.

The core reports each exception as a one-cycle strobe with a 4-bit class code, and reports each instruction fetch with a second strobe. Each of the 13 exception classes has its own stop-enable bit. An enabled class latches a stop and sets a sticky reason bit. A class whose enable is clear withdraws any pending stop request. The host reaches all registers through a small synchronous read/write port.

Top module: `dbg_halt_ctrl`

Register map (address: content): 0 control (bit0 hold-in-reset, bit1 stall); 1 mode (bit0 single-step, bit1 stall override, bit2 stops permitted); 2 stop-enable mask (bit k enables class code k); 3 stop reasons (bit k records class code k). Class codes 0 to 12 are, in order: reset, bus error, data page fault, instruction page fault, low-priority interrupt, alignment, illegal instruction, high-priority interrupt, data TLB miss, instruction TLB miss, range, system call, trap.

## Requirements
- R1: After reset, coreStall, coreHold, coreRstPulse and regErr are 0, and every register reads as 0.
- R2: A write to address 0 loads bit0 into the hold bit (seen on coreHold in the next cycle) and bit1 into the stall bit. With the override clear, coreStall follows the stall bit. Such a write also cancels a latched stop unless a stop event occurs in the same cycle.
- R3: coreRstPulse is 1 for exactly one cycle, the cycle after a control write that clears a hold bit that was 1. Writing 0 over a 0 hold bit gives no pulse.
- R4: While mode bit1 is 1, coreStall is 0 whatever the stall bit or a latched stop say.
- R5: With mode bit0 and bit2 set, a fetchValid strobe latches a stop, so coreStall is 1 from the next cycle. With mode bit0 clear, a fetch has no effect.
- R6: No stop event of any kind has an effect while coreHold is 1 or mode bit2 is 0. Reasons and coreStall are then unchanged.
- R7: An exception strobe with code k (0 to 12) whose mask bit k is 1 ORs bit k into the reason register and latches a stop.
- R8: An exception strobe with code k whose mask bit k is 0 leaves the reasons unchanged and cancels a latched stop.
- R9: Exception codes 13 to 15 are ignored: reasons and the latched stop are unchanged.
- R10: Reason bits are sticky. Only a write to address 3 changes them other than by setting bits, and that write loads the written value, ORed with any reason set in the same cycle.
- R11: An access with regSel at address 0 to 3 returns, on regRdata in the next cycle, the register content before any write of that cycle (0 for writes). An access to address 4 to 7 sets regErr in the next cycle and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 1 | Register access valid this cycle |
| regWe | input | 1 | Access is a write |
| regAddr | input | 3 | Register address |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data, registered |
| regErr | output | 1 | Unknown address accessed, registered |
| excValid | input | 1 | Exception strobe |
| excCode | input | 4 | Exception class code |
| fetchValid | input | 1 | Instruction fetch strobe |
| coreStall | output | 1 | Stall to the core |
| coreHold | output | 1 | Hold core in reset |
| coreRstPulse | output | 1 | One-cycle restart on release of hold |

## Verification
The stop logic is exercised with exceptions of enabled classes, disabled classes and codes out of range. The outcomes show apart the set path, the cancel path and the ignore path, both in coreStall and in the reason value read back. The same exception is repeated with stops not permitted and with the core held, which separates the gating from the mask. The control register is walked through 1 to 0 and 0 to 0 transitions of the hold bit, with the override on and off, so that the restart pulse is tied to the falling edge and the override is tied to the stall output alone.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  localparam int NUM_CLASS = 13;
  localparam int CODE_W    = 4;
  localparam int MODE_W    = 3;

  localparam int ADR_CTL  = 0;
  localparam int ADR_MODE = 1;
  localparam int ADR_MASK = 2;
  localparam int ADR_RSN  = 3;

  // mode register bit positions
  localparam int M_STEP  = 0;
  localparam int M_NOSTL = 1;
  localparam int M_STOPS = 2;

  typedef struct packed {
    logic wrCtl;
    logic wrMode;
    logic wrMask;
    logic wrReason;
    logic rdVal;
    logic accErr;
    logic stopSet;
    logic stopClr;
  } strobe_t;
endpackage

// File: rtl/dbg_halt_seq.sv
module dbg_halt_seq
  import dbg_halt_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic                 regSel,
  input  logic                 regWe,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 excValid,
  input  logic [CODE_W-1:0]    excCode,
  input  logic                 fetchValid,
  input  logic [MODE_W-1:0]    modeQ,
  input  logic                 holdQ,
  input  logic [NUM_CLASS-1:0] maskQ,
  output strobe_t              stb,
  output logic [NUM_CLASS-1:0] excHit
);
  logic known;
  logic permit;
  logic codeOk;
  logic [NUM_CLASS-1:0] codeHot;

  always_comb begin
    known  = (int'(regAddr) <= ADR_RSN);
    permit = modeQ[M_STOPS] && !holdQ;
    codeOk = excValid && (int'(excCode) < NUM_CLASS);
    for (int i = 0; i < NUM_CLASS; i++) begin
      codeHot[i] = codeOk && (int'(excCode) == i);
    end
    excHit = permit ? (codeHot & maskQ) : '0;

    stb.wrCtl    = regSel && regWe && (int'(regAddr) == ADR_CTL);
    stb.wrMode   = regSel && regWe && (int'(regAddr) == ADR_MODE);
    stb.wrMask   = regSel && regWe && (int'(regAddr) == ADR_MASK);
    stb.wrReason = regSel && regWe && (int'(regAddr) == ADR_RSN);
    stb.rdVal    = regSel && !regWe && known;
    stb.accErr   = regSel && !known;
    stb.stopSet  = (|excHit) || (permit && modeQ[M_STEP] && fetchValid);
    stb.stopClr  = permit && codeOk && !(|(codeHot & maskQ));
  end
endmodule

// File: rtl/dbg_halt_regs.sv
module dbg_halt_regs
  import dbg_halt_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [NUM_CLASS-1:0] excHit,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    regRdata,
  output logic                 regErr,
  output logic [MODE_W-1:0]    modeQ,
  output logic                 holdQ,
  output logic [NUM_CLASS-1:0] maskQ,
  output logic [NUM_CLASS-1:0] reasonQ,
  output logic                 coreStall,
  output logic                 coreRstPulse
);
  logic stallQ;
  logic stopQ;
  logic [DATA_W-1:0] rdMux;

  always_comb begin
    rdMux = '0;
    case (int'(regAddr))
      ADR_CTL:  rdMux = DATA_W'({stallQ, holdQ});
      ADR_MODE: rdMux = DATA_W'(modeQ);
      ADR_MASK: rdMux = DATA_W'(maskQ);
      ADR_RSN:  rdMux = DATA_W'(reasonQ);
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ        <= 1'b0;
      stallQ       <= 1'b0;
      modeQ        <= '0;
      maskQ        <= '0;
      reasonQ      <= '0;
      stopQ        <= 1'b0;
      coreRstPulse <= 1'b0;
      regRdata     <= '0;
      regErr       <= 1'b0;
    end else begin
      coreRstPulse <= stb.wrCtl && holdQ && !regWdata[0];
      if (stb.wrCtl) begin
        holdQ  <= regWdata[0];
        stallQ <= regWdata[1];
      end
      if (stb.wrMode) modeQ <= regWdata[MODE_W-1:0];
      if (stb.wrMask) maskQ <= regWdata[NUM_CLASS-1:0];
      if (stb.wrReason) reasonQ <= regWdata[NUM_CLASS-1:0] | excHit;
      else              reasonQ <= reasonQ | excHit;
      if (stb.stopSet)                    stopQ <= 1'b1;
      else if (stb.stopClr || stb.wrCtl)  stopQ <= 1'b0;
      regRdata <= stb.rdVal ? rdMux : '0;
      regErr   <= stb.accErr;
    end
  end

  assign coreStall = !modeQ[M_NOSTL] && (stallQ || stopQ);
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              regErr,
  input  logic              excValid,
  input  logic [CODE_W-1:0] excCode,
  input  logic              fetchValid,
  output logic              coreStall,
  output logic              coreHold,
  output logic              coreRstPulse
);
  strobe_t              stb;
  logic [NUM_CLASS-1:0] excHit;
  logic [MODE_W-1:0]    modeQ;
  logic                 holdQ;
  logic [NUM_CLASS-1:0] maskQ;
  logic [NUM_CLASS-1:0] reasonQ;

  dbg_halt_seq #(.ADDR_W(ADDR_W)) u_seq (
    .regSel(regSel), .regWe(regWe), .regAddr(regAddr),
    .excValid(excValid), .excCode(excCode), .fetchValid(fetchValid),
    .modeQ(modeQ), .holdQ(holdQ), .maskQ(maskQ),
    .stb(stb), .excHit(excHit)
  );

  dbg_halt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .excHit(excHit),
    .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .regErr(regErr),
    .modeQ(modeQ), .holdQ(holdQ), .maskQ(maskQ), .reasonQ(reasonQ),
    .coreStall(coreStall), .coreRstPulse(coreRstPulse)
  );

  assign coreHold = holdQ;
endmodule

// File: rtl/dbg_halt_ctrl_chk.sv
module dbg_halt_ctrl_chk
  import dbg_halt_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 regSel,
  input logic                 regWe,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [DATA_W-1:0]    regWdata,
  input logic                 regErr,
  input logic                 excValid,
  input logic [CODE_W-1:0]    excCode,
  input logic                 coreStall,
  input logic                 coreHold,
  input logic                 coreRstPulse,
  input logic [NUM_CLASS-1:0] reasonQ
);
  logic wrCtl, wrMode, wrRsn;
  assign wrCtl  = regSel && regWe && (int'(regAddr) == ADR_CTL);
  assign wrMode = regSel && regWe && (int'(regAddr) == ADR_MODE);
  assign wrRsn  = regSel && regWe && (int'(regAddr) == ADR_RSN);

  p_hold_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrCtl |=> (coreHold == $past(regWdata[0])));

  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    coreRstPulse |=> !coreRstPulse);

  p_pulse_edge_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrCtl && coreHold && !regWdata[0] |=> coreRstPulse);

  p_override_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrMode && regWdata[M_NOSTL] |=> !coreStall);

  p_bad_code_r9: assert property (@(posedge clk) disable iff (!rstN)
    excValid && (int'(excCode) >= NUM_CLASS) && !wrRsn |=> $stable(reasonQ));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    !wrRsn |=> (($past(reasonQ) & ~reasonQ) == '0));

  p_bad_addr_r11: assert property (@(posedge clk) disable iff (!rstN)
    regSel && (int'(regAddr) > ADR_RSN) |=> regErr);
endmodule

bind dbg_halt_ctrl dbg_halt_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .regSel(regSel), .regWe(regWe),
  .regAddr(regAddr), .regWdata(regWdata), .regErr(regErr),
  .excValid(excValid), .excCode(excCode), .coreStall(coreStall),
  .coreHold(coreHold), .coreRstPulse(coreRstPulse), .reasonQ(reasonQ)
);

// File: tb/dbg_halt_ctrl_tb.sv
`timescale 1ns/1ps
module dbg_halt_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regSel = 1'b0, regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        regErr;
  logic        excValid = 1'b0;
  logic [3:0]  excCode = '0;
  logic        fetchValid = 1'b0;
  logic        coreStall, coreHold, coreRstPulse;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [15:0] d;
    logic        e;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  always #2 clk = ~clk;

  dbg_halt_ctrl u_dut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .regErr(regErr), .excValid(excValid), .excCode(excCode),
    .fetchValid(fetchValid), .coreStall(coreStall), .coreHold(coreHold),
    .coreRstPulse(coreRstPulse)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one access, expected result pushed for the monitor
  task automatic acc(input logic we, input int adr, input logic [15:0] wd,
                     input logic [15:0] expD, input logic expE, input string tag);
    exp_t it;
    it.d = expD; it.e = expE; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    regSel = 1'b1; regWe = we; regAddr = 3'(adr); regWdata = wd;
    @(negedge clk);
    regSel = 1'b0; regWe = 1'b0;
  endtask

  task automatic wr(input int adr, input logic [15:0] wd, input string tag);
    acc(1'b1, adr, wd, 16'h0, (adr > 3), tag);
  endtask

  task automatic rd(input int adr, input logic [15:0] expD, input string tag);
    acc(1'b0, adr, 16'h0, expD, (adr > 3), tag);
  endtask

  task automatic exc(input int code);
    @(negedge clk);
    excValid = 1'b1; excCode = 4'(code);
    @(negedge clk);
    excValid = 1'b0;
  endtask

  task automatic fetch();
    @(negedge clk);
    fetchValid = 1'b1;
    @(negedge clk);
    fetchValid = 1'b0;
  endtask

  // monitor: compares each access result one cycle after it is taken
  initial begin
    forever begin
      @(posedge clk);
      if (regSel) begin
        @(negedge clk);
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R11 unexpected result actual=%h expected=none", regRdata);
        end else begin
          exp_t it;
          it = expQ.pop_front();
          chk({it.tag, " data"}, regRdata, it.d);
          chk({it.tag, " err"}, 16'(regErr), 16'(it.e));
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 stall", 16'(coreStall), 0);
    chk("R1 hold", 16'(coreHold), 0);
    chk("R1 pulse", 16'(coreRstPulse), 0);
    rstN = 1'b1;
    for (int a = 0; a < 4; a++) rd(a, 16'h0, "R1 reg zero");

    // R2 control register
    wr(0, 16'h2, "R2 wr stall");
    chk("R2 stall on", 16'(coreStall), 1);
    rd(0, 16'h2, "R2 rd ctl");
    wr(0, 16'h0, "R2 wr clear");
    chk("R2 stall off", 16'(coreStall), 0);
    chk("R3 no pulse 0->0", 16'(coreRstPulse), 0);

    // R3 hold and restart pulse
    wr(0, 16'h1, "R3 hold");
    chk("R2 hold on", 16'(coreHold), 1);
    chk("R3 no pulse rise", 16'(coreRstPulse), 0);
    wr(0, 16'h0, "R3 release");
    chk("R3 pulse", 16'(coreRstPulse), 1);
    chk("R3 hold off", 16'(coreHold), 0);
    @(negedge clk);
    chk("R3 pulse one cycle", 16'(coreRstPulse), 0);

    // R4 override
    wr(1, 16'h2, "R4 mode");
    wr(0, 16'h2, "R4 ctl");
    chk("R4 forced low", 16'(coreStall), 0);
    wr(1, 16'h0, "R4 mode off");
    chk("R4 released", 16'(coreStall), 1);
    wr(0, 16'h0, "R4 ctl clear");

    // R7 / R8 mask behaviour
    wr(1, 16'h4, "R7 stops on");
    exc(3);
    chk("R8 masked stall", 16'(coreStall), 0);
    rd(3, 16'h0, "R8 masked reason");
    wr(2, 16'h1008, "R7 mask");
    exc(3);
    chk("R7 stall", 16'(coreStall), 1);
    rd(3, 16'h0008, "R7 reason 3");
    exc(12);
    rd(3, 16'h1008, "R7 reason 12");
    exc(5);
    chk("R8 cancel", 16'(coreStall), 0);
    rd(3, 16'h1008, "R10 sticky after cancel");

    // R9 unknown codes
    exc(3);
    exc(14);
    chk("R9 stall kept", 16'(coreStall), 1);
    rd(3, 16'h1008, "R9 reason kept");
    wr(0, 16'h0, "R2 ctl cancels stop");
    chk("R2 stop cancelled", 16'(coreStall), 0);
    exc(15);
    chk("R9 no stall", 16'(coreStall), 0);

    // R10 host write
    wr(3, 16'h0, "R10 clear");
    rd(3, 16'h0, "R10 cleared");

    // R6 gating
    wr(1, 16'h0, "R6 stops off");
    exc(3);
    chk("R6 off stall", 16'(coreStall), 0);
    rd(3, 16'h0, "R6 off reason");
    wr(1, 16'h4, "R6 stops on");
    wr(0, 16'h1, "R6 hold");
    exc(12);
    chk("R6 held stall", 16'(coreStall), 0);
    rd(3, 16'h0, "R6 held reason");
    wr(0, 16'h0, "R6 release");

    // R5 single step
    wr(1, 16'h5, "R5 step on");
    fetch();
    chk("R5 step stop", 16'(coreStall), 1);
    rd(3, 16'h0, "R5 no reason");
    wr(0, 16'h0, "R5 resume");
    wr(1, 16'h4, "R5 step off");
    fetch();
    chk("R5 no step", 16'(coreStall), 0);

    // R11 unknown addresses
    rd(5, 16'h0, "R11 bad read");
    wr(6, 16'hFFFF, "R11 bad write");
    rd(0, 16'h0, "R11 ctl intact");
    rd(1, 16'h4, "R11 mode intact");
    rd(2, 16'h1008, "R11 mask intact");
    rd(3, 16'h0, "R11 reason intact");

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R11 pending results actual=%0d expected=0", expQ.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule